// File: doc/BRIEF.md
# Interrupt presentation controller

This block sits beside one processor and decides which interrupt that processor sees. It keeps a single presented interrupt (a 24-bit source number and its priority), the processor's current priority, and a request priority for the inter-processor interrupt (IPI). It drives one level interrupt line toward the CPU. Lower numbers are more favoured. A source number of zero means nothing is presented.

Software works the block through one command per cycle. The commands are: set the processor priority, set the IPI request priority, accept the presented interrupt, and signal end-of-interrupt. A source controller offers interrupts as a source number with a priority. Any interrupt that is refused or displaced is handed back to that controller as a reject in the same cycle. End-of-interrupt notices and a resend request travel back on their own outputs. A command and an offer never arrive in the same cycle. The source controller has to hold to this rule.

Top module: `ipres_ctrl`

## Requirements
- R1: Synchronous reset sets the interrupt word to zero and lowers the output. It sets the pending priority and the IPI request priority both to 0xFF. An accept straight after reset yields a processor priority of 0xFF. Raising the processor priority after reset presents no IPI.
- R2: An offer (`ofr_valid`) of priority p is refused when p is not below the processor priority, or when an interrupt is pending with priority at most p. In that case `rej_valid` pulses with `rej_src` equal to the offered source in the same cycle, and the interrupt word is unchanged.
- R3: An offer that is not refused loads its source and priority and raises `irq_out`. A pending external interrupt that it displaces is rejected in the same cycle. `irq_out` is high exactly when the source field of the word is nonzero.
- R4: Writing the IPI request priority (`cmd_op`=1, value in `cmd_data[7:0]`) with a value below the processor priority presents source `IPI_SRC` (default 2) at that priority and raises the output. It does not do so when a pending interrupt already has priority at most the request. A displaced external interrupt is rejected.
- R5: A presented IPI is never rejected, whether it is displaced by an offer or cleared by a priority write.
- R6: Writing a lower processor priority (`cmd_op`=0, value in `cmd_data[7:0]`) that is at most the pending priority clears the presented interrupt and lowers the output. It rejects the cleared source if that source is external.
- R7: Writing a higher processor priority pulses `resend` in that cycle. It also presents the IPI when the request priority is below the new value and the pending-priority test allows it.
- R8: An accept (`cmd_op`=2) sees the full word on `rd_data` in its cycle. Afterwards the processor priority equals the accepted priority (0xFF if nothing was pending), the source is zero, and the output is low.
- R9: An end-of-interrupt (`cmd_op`=3) pulses `eoi_valid` with `eoi_src` = `cmd_data[23:0]` in the same cycle. It then sets the processor priority to `cmd_data[31:24]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Software command strobe |
| cmd_op | input | 2 | 0 set priority, 1 set IPI request, 2 accept, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| rd_data | output | 32 | Interrupt word: processor priority [31:24], source [23:0] |
| ofr_valid | input | 1 | Interrupt offer strobe; never with cmd_valid |
| ofr_src | input | 24 | Offered source number |
| ofr_prio | input | 8 | Offered priority |
| rej_valid | output | 1 | Reject notice to the source controller |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt notice |
| eoi_src | output | 24 | Source being completed |
| resend | output | 1 | Request that the source controller resend rejected interrupts |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The hardest states to reach are an IPI pending under a raised processor priority, and the reset value of the IPI request priority, which has no read port. The stimulus first lowers the processor priority below a stored request. Raising it again must then present the IPI without any reject. A later lowering must clear it, again without a reject. The request priority's reset value is checked by loading a request, resetting, and then raising the processor priority: an IPI must not appear. Offer acceptance is swept over every pair of processor and offer priorities, and over every pair of pending and offered priorities, including ties.

// File: rtl/ipres_pkg.sv
package ipres_pkg;

    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;

    localparam prio_t PRIO_NONE = '1;

    typedef enum logic [1:0] {
        OP_SET_PRIO = 2'd0,
        OP_SET_IPI  = 2'd1,
        OP_ACCEPT   = 2'd2,
        OP_EOI      = 2'd3
    } cmd_op_e;

    typedef struct packed {
        prio_t cur_prio;   // processor priority
        src_t  src;        // presented source, zero when none
        prio_t pend_prio;  // priority of the presented source
        prio_t ipi_prio;   // IPI request priority
        logic  ext_owned;  // presented source came from the source controller
        logic  irq;        // line to the processor
    } pres_state_t;

    // a is strictly more favoured than b
    function automatic logic beats(prio_t a, prio_t b);
        return a < b;
    endfunction

    // a presented interrupt is at least as favoured as the candidate
    function automatic logic held_off(src_t s, prio_t pend, prio_t cand);
        return (s != '0) && (pend <= cand);
    endfunction

endpackage

// File: rtl/ipres_offer_eval.sv
module ipres_offer_eval
    import ipres_pkg::*;
(
    input  prio_t cur_prio,
    input  src_t  cur_src,
    input  prio_t pend_prio,
    input  prio_t cand_prio,
    output logic  take
);
    always_comb begin
        take = beats(cand_prio, cur_prio) && !held_off(cur_src, pend_prio, cand_prio);
    end
endmodule

// File: rtl/ipres_ipi_eval.sv
module ipres_ipi_eval
    import ipres_pkg::*;
(
    input  src_t  cur_src,
    input  prio_t pend_prio,
    input  prio_t req_prio,
    output logic  fire
);
    always_comb begin
        fire = !held_off(cur_src, pend_prio, req_prio);
    end
endmodule

// File: rtl/ipres_ctrl.sv
module ipres_ctrl
    import ipres_pkg::*;
#(
    parameter src_t IPI_SRC = src_t'(2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              ofr_valid,
    input  logic [SRC_W-1:0]  ofr_src,
    input  logic [PRIO_W-1:0] ofr_prio,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend,
    output logic              irq_out
);
    pres_state_t st, nxt;
    prio_t       wr_prio;
    logic        offer_take, ipi_on_write, ipi_on_stored;
    cmd_op_e     op;

    assign wr_prio = cmd_data[PRIO_W-1:0];
    assign op      = cmd_op_e'(cmd_op);

    ipres_offer_eval u_offer (
        .cur_prio (st.cur_prio),
        .cur_src  (st.src),
        .pend_prio(st.pend_prio),
        .cand_prio(ofr_prio),
        .take     (offer_take)
    );

    ipres_ipi_eval u_ipi_wr (
        .cur_src  (st.src),
        .pend_prio(st.pend_prio),
        .req_prio (wr_prio),
        .fire     (ipi_on_write)
    );

    ipres_ipi_eval u_ipi_st (
        .cur_src  (st.src),
        .pend_prio(st.pend_prio),
        .req_prio (st.ipi_prio),
        .fire     (ipi_on_stored)
    );

    always_comb begin
        nxt       = st;
        rej_valid = 1'b0;
        rej_src   = '0;
        eoi_valid = 1'b0;
        eoi_src   = '0;
        resend    = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_SET_PRIO: begin
                    nxt.cur_prio = wr_prio;
                    if (beats(wr_prio, st.cur_prio)) begin
                        if (st.src != '0 && wr_prio <= st.pend_prio) begin
                            rej_valid     = st.ext_owned;
                            rej_src       = st.ext_owned ? st.src : '0;
                            nxt.src       = '0;
                            nxt.pend_prio = PRIO_NONE;
                            nxt.ext_owned = 1'b0;
                            nxt.irq       = 1'b0;
                        end
                    end else if (beats(st.cur_prio, wr_prio)) begin
                        resend = 1'b1;
                        if (beats(st.ipi_prio, wr_prio) && ipi_on_stored) begin
                            rej_valid     = st.ext_owned && st.src != '0;
                            rej_src       = rej_valid ? st.src : '0;
                            nxt.src       = IPI_SRC;
                            nxt.pend_prio = st.ipi_prio;
                            nxt.ext_owned = 1'b0;
                            nxt.irq       = 1'b1;
                        end
                    end
                end
                OP_SET_IPI: begin
                    nxt.ipi_prio = wr_prio;
                    if (beats(wr_prio, st.cur_prio) && ipi_on_write) begin
                        rej_valid     = st.ext_owned && st.src != '0;
                        rej_src       = rej_valid ? st.src : '0;
                        nxt.src       = IPI_SRC;
                        nxt.pend_prio = wr_prio;
                        nxt.ext_owned = 1'b0;
                        nxt.irq       = 1'b1;
                    end
                end
                OP_ACCEPT: begin
                    nxt.cur_prio  = st.pend_prio;
                    nxt.src       = '0;
                    nxt.pend_prio = PRIO_NONE;
                    nxt.ext_owned = 1'b0;
                    nxt.irq       = 1'b0;
                end
                OP_EOI: begin
                    nxt.cur_prio = cmd_data[WORD_W-1:SRC_W];
                    eoi_valid    = 1'b1;
                    eoi_src      = cmd_data[SRC_W-1:0];
                end
                default: ;
            endcase
        end else if (ofr_valid) begin
            rej_valid = 1'b1;
            if (offer_take) begin
                rej_valid     = st.ext_owned && st.src != '0;
                rej_src       = rej_valid ? st.src : '0;
                nxt.src       = ofr_src;
                nxt.pend_prio = ofr_prio;
                nxt.ext_owned = 1'b1;
                nxt.irq       = 1'b1;
            end else begin
                rej_src = ofr_src;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{cur_prio: '0, src: '0, pend_prio: PRIO_NONE,
                    ipi_prio: PRIO_NONE, ext_owned: 1'b0, irq: 1'b0};
        end else begin
            st <= nxt;
        end
    end

    assign rd_data = {st.cur_prio, st.src};
    assign irq_out = st.irq;

endmodule

// File: rtl/ipres_ctrl_chk.sv
module ipres_ctrl_chk
    import ipres_pkg::*;
#(
    parameter src_t IPI_SRC = src_t'(2)
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [WORD_W-1:0] cmd_data,
    input logic [WORD_W-1:0] rd_data,
    input logic              ofr_valid,
    input logic [SRC_W-1:0]  ofr_src,
    input logic [PRIO_W-1:0] ofr_prio,
    input logic              rej_valid,
    input logic [SRC_W-1:0]  rej_src,
    input logic              eoi_valid,
    input logic [SRC_W-1:0]  eoi_src,
    input logic              resend,
    input logic              irq_out
);
    logic offer_only;
    assign offer_only = ofr_valid && !cmd_valid;

    AST_REFUSE_REJECTS: assert property (@(posedge clk) disable iff (rst)
        offer_only && ofr_prio >= rd_data[WORD_W-1:SRC_W] |-> rej_valid && rej_src == ofr_src); // R2

    AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        offer_only && ofr_prio >= rd_data[WORD_W-1:SRC_W] |=> $stable(rd_data)); // R2

    AST_OFFER_LOADS: assert property (@(posedge clk) disable iff (rst)
        offer_only && ofr_prio < rd_data[WORD_W-1:SRC_W] && rd_data[SRC_W-1:0] == '0
        |=> irq_out && rd_data[SRC_W-1:0] == $past(ofr_src)); // R3

    AST_LINE_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (rst)
        irq_out == (rd_data[SRC_W-1:0] != '0)); // R3

    AST_IPI_NO_REJECT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 2'd0 && rd_data[SRC_W-1:0] == IPI_SRC
        && cmd_data[PRIO_W-1:0] < rd_data[WORD_W-1:SRC_W] |-> !rej_valid); // R5

    AST_RESEND_ON_RAISE: assert property (@(posedge clk) disable iff (rst)
        resend |-> cmd_valid && cmd_op == 2'd0
        && cmd_data[PRIO_W-1:0] > rd_data[WORD_W-1:SRC_W]); // R7

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 2'd2 |=> !irq_out && rd_data[SRC_W-1:0] == '0); // R8

    AST_EOI_FORWARD: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 2'd3 |-> eoi_valid && eoi_src == cmd_data[SRC_W-1:0]); // R9

    AST_EOI_PRIO: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 2'd3 |=> rd_data[WORD_W-1:SRC_W] == $past(cmd_data[WORD_W-1:SRC_W])); // R9

    AST_EOI_ONLY_CMD: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> cmd_valid && cmd_op == 2'd3); // R9
endmodule

bind ipres_ctrl ipres_ctrl_chk #(.IPI_SRC(IPI_SRC)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rd_data(rd_data), .ofr_valid(ofr_valid), .ofr_src(ofr_src), .ofr_prio(ofr_prio),
    .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .resend(resend), .irq_out(irq_out)
);

// File: tb/ipres_ctrl_tb.sv
module ipres_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_data = '0;
    logic [31:0] rd_data;
    logic        ofr_valid = 1'b0;
    logic [23:0] ofr_src = '0;
    logic [7:0]  ofr_prio = '0;
    logic        rej_valid, eoi_valid, resend, irq_out;
    logic [23:0] rej_src, eoi_src;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ipres_ctrl u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rd_data(rd_data), .ofr_valid(ofr_valid), .ofr_src(ofr_src), .ofr_prio(ofr_prio),
        .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend(resend), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drv_cmd(input logic [1:0] op, input logic [31:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; #1;
    endtask

    task automatic drv_ofr(input logic [23:0] s, input logic [7:0] p);
        ofr_valid = 1'b1; ofr_src = s; ofr_prio = p; #1;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        cmd_valid = 1'b0; ofr_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 word", rd_data, 32'h0);
        chk("R1 line", {31'b0, irq_out}, 32'h0);

        // sweep processor priority against offered priority, nothing pending
        for (int c = 0; c <= 8; c++) begin
            for (int p = 0; p <= 8; p++) begin
                logic take;
                logic [23:0] s;
                take = (p < c);
                s = 24'h100 + 24'(p);
                drv_cmd(2'd3, {8'(c), 24'h0}); tick();
                drv_ofr(s, 8'(p));
                chk("R2 reject strobe", {31'b0, rej_valid}, {31'b0, !take});
                if (!take) chk("R2 reject src", {8'h0, rej_src}, {8'h0, s});
                tick();
                chk("R3 word", rd_data, {8'(c), take ? s : 24'h0});
                chk("R3 line", {31'b0, irq_out}, {31'b0, take});
                drv_cmd(2'd2, 32'h0);
                chk("R8 read", rd_data, {8'(c), take ? s : 24'h0});
                tick();
                chk("R8 after", rd_data, {take ? 8'(p) : 8'hFF, 24'h0});
            end
        end

        // sweep pending priority against offered priority
        for (int p1 = 0; p1 <= 7; p1++) begin
            for (int p2 = 0; p2 <= 7; p2++) begin
                logic t2;
                logic [23:0] a, b;
                a = 24'h200 + 24'(p1);
                b = 24'h300 + 24'(p2);
                t2 = (p2 < p1);
                drv_cmd(2'd3, 32'hFF00_0000); tick();
                drv_ofr(a, 8'(p1)); tick();
                drv_ofr(b, 8'(p2));
                chk("R3 displace strobe", {31'b0, rej_valid}, 32'h1);
                chk("R2/R3 reject src", {8'h0, rej_src}, {8'h0, t2 ? a : b});
                tick();
                chk("R3 winner", rd_data, {8'hFF, t2 ? b : a});
                drv_cmd(2'd2, 32'h0); tick();
                chk("R8 prio", rd_data, {t2 ? 8'(p2) : 8'(p1), 24'h0});
            end
        end

        // IPI presentation and displacement
        drv_cmd(2'd3, 32'hFF00_0000); tick();
        drv_cmd(2'd1, 32'h5);
        chk("R4 no reject", {31'b0, rej_valid}, 32'h0);
        tick();
        chk("R4 ipi word", rd_data, 32'hFF00_0002);
        chk("R4 line", {31'b0, irq_out}, 32'h1);
        drv_ofr(24'h77, 8'h3);
        chk("R5 ipi displaced", {31'b0, rej_valid}, 32'h0);
        tick();
        chk("R3 over ipi", rd_data, 32'hFF00_0077);
        drv_cmd(2'd2, 32'h0); tick();
        chk("R8 prio", rd_data, 32'h0300_0000);
        drv_cmd(2'd1, 32'h1); tick();
        chk("R4 empty", rd_data, 32'h0300_0002);
        drv_cmd(2'd2, 32'h0); tick();
        chk("R8 ipi prio", rd_data, 32'h0100_0000);
        drv_cmd(2'd3, 32'hFF00_0002);
        chk("R9 strobe", {31'b0, eoi_valid}, 32'h1);
        chk("R9 src", {8'h0, eoi_src}, 32'h2);
        tick();
        chk("R9 prio", rd_data, 32'hFF00_0000);

        // priority lowering and raising with an IPI request of 1 stored
        drv_cmd(2'd0, 32'h0);
        chk("R7 no resend on lower", {31'b0, resend}, 32'h0);
        tick();
        chk("R6 empty lower", rd_data, 32'h0);
        drv_cmd(2'd0, 32'h10);
        chk("R7 resend", {31'b0, resend}, 32'h1);
        chk("R5 no reject", {31'b0, rej_valid}, 32'h0);
        tick();
        chk("R7 ipi rerun", rd_data, 32'h1000_0002);
        drv_cmd(2'd0, 32'h1);
        chk("R5 ipi cleared", {31'b0, rej_valid}, 32'h0);
        tick();
        chk("R6 cleared", rd_data, 32'h0100_0000);
        chk("R6 line", {31'b0, irq_out}, 32'h0);
        drv_cmd(2'd1, 32'hFF); tick();
        drv_cmd(2'd0, 32'hFF);
        chk("R7 resend", {31'b0, resend}, 32'h1);
        tick();
        chk("R7 no ipi", rd_data, 32'hFF00_0000);

        // external interrupt cleared by priority lowering
        drv_ofr(24'h55, 8'h4); tick();
        drv_cmd(2'd0, 32'h6);
        chk("R6 kept", {31'b0, rej_valid}, 32'h0);
        tick();
        chk("R6 kept word", rd_data, 32'h0600_0055);
        drv_cmd(2'd0, 32'h4);
        chk("R6 reject", {31'b0, rej_valid}, 32'h1);
        chk("R6 reject src", {8'h0, rej_src}, 32'h55);
        tick();
        chk("R6 cleared", rd_data, 32'h0400_0000);
        chk("R6 line", {31'b0, irq_out}, 32'h0);

        // IPI displaces external
        drv_cmd(2'd0, 32'hFF); tick();
        drv_ofr(24'h66, 8'h6); tick();
        drv_cmd(2'd1, 32'h3);
        chk("R4 reject", {31'b0, rej_valid}, 32'h1);
        chk("R4 reject src", {8'h0, rej_src}, 32'h66);
        tick();
        chk("R4 word", rd_data, 32'hFF00_0002);
        drv_cmd(2'd1, 32'h5);
        chk("R4 held", {31'b0, rej_valid}, 32'h0);
        tick();
        drv_cmd(2'd2, 32'h0); tick();
        chk("R4 prio kept", rd_data, 32'h0300_0000);

        // equal offered and processor priority
        drv_cmd(2'd3, 32'h0800_0000); tick();
        drv_ofr(24'h88, 8'h8);
        chk("R2 tie", {8'h0, rej_src}, 32'h88);
        tick();
        chk("R2 tie word", rd_data, 32'h0800_0000);

        // reset values
        drv_cmd(2'd1, 32'h5); tick();
        chk("R4 before reset", rd_data, 32'h0800_0002);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 word", rd_data, 32'h0);
        chk("R1 line", {31'b0, irq_out}, 32'h0);
        drv_cmd(2'd2, 32'h0); tick();
        chk("R1 pend prio", rd_data, 32'hFF00_0000);
        drv_cmd(2'd0, 32'h0); tick();
        drv_cmd(2'd0, 32'hFF); tick();
        chk("R1 ipi request", rd_data, 32'hFF00_0000);
        chk("R1 line", {31'b0, irq_out}, 32'h0);

        report();
    end
endmodule